// File: doc/BRIEF.md
# I/O MMU Control and Fault Register Block

This block is the register front end of an I/O memory management unit. Software reaches it through a simple register port, with one write strobe and a combinational read. It holds the translation mode, the table base, a configuration word, the fault status bits and four fault address capture registers. It also issues invalidation commands to the translation cache.

The translation logic reports faults to this block. Each fault carries a type code and an address. The block latches the matching status bit, which raises a level interrupt. It stores the address in the capture register chosen by the fault type. It also forces the translation path into the blocked mode. The block stays there until software explicitly re-enables translation, and control writes of any other value are ignored until then.

Invalidation requests leave the block as single-cycle pulses. A full invalidation pulse follows a flush write or a table base write. A per-entry pulse carries a page-aligned address.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset the mode is off (modeEnable=0, modeBlock=0), irq is low, both invalidate pulses are low, and every readable register returns 0 except the version word.
- R2: A write to the control offset 0x000 with 0x5 selects run mode (modeEnable=1, modeBlock=0). A write of 0x7 selects blocked mode (both 1). Any other value selects off mode. The control offset reads back 0x5, 0x7 or 0x0 to match the mode.
- R3: Bit 0 of the status word at 0x008 reads 1 from the cycle after a clock edge at which the mode was blocked and drainIdle was high. Otherwise it reads 0.
- R4: A fault with faultValid=1 sets bit faultType of the interrupt status word at 0x018. The bit for each type is: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. irq is high whenever any status bit is set.
- R5: The fault address is captured according to the fault type. Type 0 goes to 0x024 and type 3 goes to 0x030. Types 1, 4 and 5 go to 0x02C. Types 2, 6 and 7 go to 0x028. The other capture registers keep their values.
- R6: Any fault puts the mode into blocked. After that, control writes other than 0x5 are ignored until a 0x5 write. A fault in the same cycle as a 0x5 write wins.
- R7: A write to 0x01C clears each status bit whose data bit is 1 and leaves the others unchanged. A fault of the same type in the same cycle keeps that bit set.
- R8: A write to 0x00C with data bit 0 set gives a one-cycle invAllPulse in the following cycle. With bit 0 clear, no pulse is given.
- R9: A write to 0x010 with data bit 0 set gives a one-cycle invEntryPulse in the following cycle. During the pulse, invEntryAddr holds the written value with its low PAGE_SHIFT bits cleared. With bit 0 clear, no pulse is given.
- R10: A write to the table base offset 0x014 stores the value, which reads back there, and gives an invAllPulse in the following cycle.
- R11: The version word at 0x034 returns the major number in bits [31:28] and the minor number in bits [27:21], with zeros below. The config word at 0x004 reads back as written. Writes to 0x008, 0x018 and 0x034 have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| drainIdle | input | 1 | Translation path has no traffic in flight |
| faultValid | input | 1 | Fault event from translation logic |
| faultType | input | 3 | Fault type code |
| faultAddr | input | DATA_W | Faulting address |
| modeEnable | output | 1 | Translation enabled |
| modeBlock | output | 1 | Translation held blocked |
| irq | output | 1 | Level interrupt, OR of status bits |
| invAllPulse | output | 1 | Invalidate-all command pulse |
| invEntryPulse | output | 1 | Invalidate-entry command pulse |
| invEntryAddr | output | DATA_W | Page-aligned address for the entry invalidation |

## Verification
The assertions check the following on every cycle: a fault always lands in blocked mode with the interrupt raised, the interrupt stays up until a clear write, a run write with no fault enables translation, and every invalidate pulse has a matching earlier write with an aligned address. The bench scenarios are needed for the rest: the routing of each fault type to its capture register, that control writes are ignored while a fault hold is active, the timing of the drain acknowledge, and the races between clear and fault, and between run and fault. These are checked against a behavioural model on every clock.

// File: rtl/mmu_reg_pkg.sv
package mmu_reg_pkg;
  localparam int unsigned OFF_CTRL  = 'h000;
  localparam int unsigned OFF_CFG   = 'h004;
  localparam int unsigned OFF_STAT  = 'h008;
  localparam int unsigned OFF_FLUSH = 'h00C;
  localparam int unsigned OFF_FENT  = 'h010;
  localparam int unsigned OFF_BASE  = 'h014;
  localparam int unsigned OFF_ISTAT = 'h018;
  localparam int unsigned OFF_ICLR  = 'h01C;
  localparam int unsigned OFF_PFA   = 'h024;
  localparam int unsigned OFF_WFA   = 'h028;
  localparam int unsigned OFF_RFA   = 'h02C;
  localparam int unsigned OFF_SLV   = 'h030;
  localparam int unsigned OFF_VER   = 'h034;

  localparam int unsigned CTRL_RUN   = 'h5;
  localparam int unsigned CTRL_BLOCK = 'h7;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_BLOCK = 2'd2
  } mode_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic wrFlush;
    logic wrFlushEnt;
    logic wrBase;
    logic wrIntClr;
  } regStrobes_t;

  // capture register index: 0 page, 1 read side, 2 write side, 3 slave
  function automatic logic [1:0] faultDest(input logic [2:0] ftype);
    case (ftype)
      3'd0:                faultDest = 2'd0;
      3'd3:                faultDest = 2'd3;
      3'd1, 3'd4, 3'd5:    faultDest = 2'd1;
      default:             faultDest = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/mmu_reg_ctrl.sv
module mmu_reg_ctrl
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              faultValid,
  output regStrobes_t       strb,
  output mode_e             mode,
  output logic              invAllPulse,
  output logic              invEntryPulse,
  output logic [DATA_W-1:0] invEntryAddr
);
  logic faultHold;
  logic isRun, isBlock;

  assign isRun   = (regWdata == DATA_W'(CTRL_RUN));
  assign isBlock = (regWdata == DATA_W'(CTRL_BLOCK));

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_W'(OFF_CTRL):  strb.wrCtrl     = 1'b1;
        ADDR_W'(OFF_CFG):   strb.wrCfg      = 1'b1;
        ADDR_W'(OFF_FLUSH): strb.wrFlush    = 1'b1;
        ADDR_W'(OFF_FENT):  strb.wrFlushEnt = 1'b1;
        ADDR_W'(OFF_BASE):  strb.wrBase     = 1'b1;
        ADDR_W'(OFF_ICLR):  strb.wrIntClr   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_OFF;
      faultHold <= 1'b0;
    end else if (faultValid) begin
      mode      <= MODE_BLOCK;
      faultHold <= 1'b1;
    end else if (strb.wrCtrl) begin
      if (isRun) begin
        mode      <= MODE_RUN;
        faultHold <= 1'b0;
      end else if (!faultHold) begin
        mode <= isBlock ? MODE_BLOCK : MODE_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invAllPulse   <= 1'b0;
      invEntryPulse <= 1'b0;
      invEntryAddr  <= '0;
    end else begin
      invAllPulse   <= (strb.wrFlush && regWdata[0]) || strb.wrBase;
      invEntryPulse <= strb.wrFlushEnt && regWdata[0];
      if (strb.wrFlushEnt && regWdata[0])
        invEntryAddr <= {regWdata[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/mmu_reg_dpath.sv
module mmu_reg_dpath
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_FAULTS = 8,
  parameter int VER_MAJOR  = 3,
  parameter int VER_MINOR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobes_t       strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  mode_e             mode,
  input  logic              drainIdle,
  input  logic              faultValid,
  input  logic [2:0]        faultType,
  input  logic [DATA_W-1:0] faultAddr,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  localparam int NUM_CAPT = 4;
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'({VER_MAJOR[3:0], VER_MINOR[6:0], 21'd0});

  logic [DATA_W-1:0] cfgQ, baseQ;
  logic              ackQ;
  logic [NUM_FAULTS-1:0] statusQ, statusD;
  logic [NUM_CAPT-1:0][DATA_W-1:0] captQ, captD;
  logic [1:0] dest;

  assign dest = faultDest(faultType);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FAULTS; gi++) begin : gStat
      assign statusD[gi] = (faultValid && faultType == 3'(gi)) ||
                           (statusQ[gi] && !(strb.wrIntClr && regWdata[gi]));
    end
    for (gi = 0; gi < NUM_CAPT; gi++) begin : gCapt
      assign captD[gi] = (faultValid && dest == 2'(gi)) ? faultAddr : captQ[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ    <= '0;
      baseQ   <= '0;
      ackQ    <= 1'b0;
      statusQ <= '0;
      captQ   <= '0;
    end else begin
      if (strb.wrCfg)  cfgQ  <= regWdata;
      if (strb.wrBase) baseQ <= regWdata;
      ackQ    <= (mode == MODE_BLOCK) && drainIdle;
      statusQ <= statusD;
      captQ   <= captD;
    end
  end

  assign irq = |statusQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(OFF_CTRL):  regRdata = (mode == MODE_RUN)   ? DATA_W'(CTRL_RUN) :
                                     (mode == MODE_BLOCK) ? DATA_W'(CTRL_BLOCK) : '0;
      ADDR_W'(OFF_CFG):   regRdata = cfgQ;
      ADDR_W'(OFF_STAT):  regRdata = DATA_W'(ackQ);
      ADDR_W'(OFF_BASE):  regRdata = baseQ;
      ADDR_W'(OFF_ISTAT): regRdata = DATA_W'(statusQ);
      ADDR_W'(OFF_PFA):   regRdata = captQ[0];
      ADDR_W'(OFF_RFA):   regRdata = captQ[1];
      ADDR_W'(OFF_WFA):   regRdata = captQ[2];
      ADDR_W'(OFF_SLV):   regRdata = captQ[3];
      ADDR_W'(OFF_VER):   regRdata = VER_WORD;
      default: ;
    endcase
  end
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int VER_MAJOR  = 3,
  parameter int VER_MINOR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              drainIdle,
  input  logic              faultValid,
  input  logic [2:0]        faultType,
  input  logic [DATA_W-1:0] faultAddr,
  output logic              modeEnable,
  output logic              modeBlock,
  output logic              irq,
  output logic              invAllPulse,
  output logic              invEntryPulse,
  output logic [DATA_W-1:0] invEntryAddr
);
  regStrobes_t strb;
  mode_e       mode;

  mmu_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) uCtrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .faultValid(faultValid), .strb(strb), .mode(mode),
    .invAllPulse(invAllPulse), .invEntryPulse(invEntryPulse),
    .invEntryAddr(invEntryAddr)
  );

  mmu_reg_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FAULTS(8),
                  .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) uDpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .mode(mode), .drainIdle(drainIdle),
    .faultValid(faultValid), .faultType(faultType), .faultAddr(faultAddr),
    .regRdata(regRdata), .irq(irq)
  );

  assign modeEnable = (mode != MODE_OFF);
  assign modeBlock  = (mode == MODE_BLOCK);
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              faultValid,
  input logic              modeEnable,
  input logic              modeBlock,
  input logic              irq,
  input logic              invAllPulse,
  input logic              invEntryPulse,
  input logic [DATA_W-1:0] invEntryAddr
);
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |=> (modeEnable && modeBlock)); // R6
  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_W'(OFF_CTRL) && regWdata == DATA_W'(CTRL_RUN) && !faultValid)
      |=> (modeEnable && !modeBlock)); // R2
  AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |=> irq); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(regWrEn && regAddr == ADDR_W'(OFF_ICLR))) |=> irq); // R7
  AST_INVALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    invAllPulse |-> $past(regWrEn && ((regAddr == ADDR_W'(OFF_FLUSH) && regWdata[0]) ||
                                      regAddr == ADDR_W'(OFF_BASE)))); // R8
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    invEntryPulse |-> (invEntryAddr[PAGE_SHIFT-1:0] == '0)); // R9
  AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    invEntryPulse |-> $past(regWrEn && regAddr == ADDR_W'(OFF_FENT) && regWdata[0])); // R9
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) uChk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
  .faultValid(faultValid), .modeEnable(modeEnable), .modeBlock(modeBlock), .irq(irq),
  .invAllPulse(invAllPulse), .invEntryPulse(invEntryPulse), .invEntryAddr(invEntryAddr)
);

// File: tb/sim_mmu_ctrl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        drainIdle = 1'b0;
  logic        faultValid = 1'b0;
  logic [2:0]  faultType = '0;
  logic [31:0] faultAddr = '0;
  logic        modeEnable, modeBlock, irq, invAllPulse, invEntryPulse;
  logic [31:0] invEntryAddr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .drainIdle(drainIdle),
    .faultValid(faultValid), .faultType(faultType), .faultAddr(faultAddr),
    .modeEnable(modeEnable), .modeBlock(modeBlock), .irq(irq),
    .invAllPulse(invAllPulse), .invEntryPulse(invEntryPulse),
    .invEntryAddr(invEntryAddr)
  );

  // behavioural reference model
  int          mMode;
  bit          mHold, mAck, mInvAll, mInvEnt;
  logic [7:0]  mStat;
  logic [31:0] mCapt [4];
  logic [31:0] mBase, mCfg, mEntAddr;

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return 32'(mMode);
      8'h04: return mCfg;
      8'h08: return {31'd0, mAck};
      8'h14: return mBase;
      8'h18: return {24'd0, mStat};
      8'h24: return mCapt[0];
      8'h2C: return mCapt[1];
      8'h28: return mCapt[2];
      8'h30: return mCapt[3];
      8'h34: return 32'h3060_0000;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mHold = 0; mAck = 0; mInvAll = 0; mInvEnt = 0;
      mStat = 0; mBase = 0; mCfg = 0; mEntAddr = 0;
      for (int i = 0; i < 4; i++) mCapt[i] = 0;
    end else begin
      bit newAck;
      newAck = (mMode == 7) && drainIdle;
      mInvAll = 0; mInvEnt = 0;
      if (regWrEn) begin
        case (regAddr)
          8'h00: if (regWdata == 5) begin mMode = 5; mHold = 0; end
                 else if (!mHold) mMode = (regWdata == 7) ? 7 : 0;
          8'h04: mCfg = regWdata;
          8'h0C: if (regWdata[0]) mInvAll = 1;
          8'h10: if (regWdata[0]) begin mInvEnt = 1; mEntAddr = regWdata & 32'hFFFF_F000; end
          8'h14: begin mBase = regWdata; mInvAll = 1; end
          8'h1C: mStat = mStat & ~regWdata[7:0];
          default: ;
        endcase
      end
      if (faultValid) begin
        mStat[faultType] = 1'b1;
        mMode = 7; mHold = 1;
        case (faultType)
          3'd0: mCapt[0] = faultAddr;
          3'd3: mCapt[3] = faultAddr;
          3'd1, 3'd4, 3'd5: mCapt[1] = faultAddr;
          default: mCapt[2] = faultAddr;
        endcase
      end
      mAck = newAck;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, well before the next edge
  always @(posedge clk) begin
    #8;
    if (rst_n && !done) begin
      chk("R2 modeEnable", 32'(modeEnable), 32'(mMode != 0));
      chk("R6 modeBlock", 32'(modeBlock), 32'(mMode == 7));
      chk("R4 irq", 32'(irq), 32'(|mStat));
      chk("R8 invAllPulse", 32'(invAllPulse), 32'(mInvAll));
      chk("R9 invEntryPulse", 32'(invEntryPulse), 32'(mInvEnt));
      if (mInvEnt) chk("R9 invEntryAddr", invEntryAddr, mEntAddr);
      chk("R11 regRdata", regRdata, expRead(regAddr));
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 0; regAddr = 8'hFC;
  endtask

  task automatic flt(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk); faultValid = 1; faultType = t; faultAddr = a;
    @(negedge clk); faultValid = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regWrEn = 0; regAddr = a;
    #2; chk(tag, regRdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #2;
    chk("R1 modeEnable", 32'(modeEnable), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pulses", {30'd0, invAllPulse, invEntryPulse}, 0);
    rd(8'h00, 0, "R1 ctrl"); rd(8'h18, 0, "R1 istat"); rd(8'h24, 0, "R1 pfa");
    // R11 version, config, unmapped, read-only writes ignored
    rd(8'h34, 32'h3060_0000, "R11 version");
    wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, 32'hA5A5_0F0F, "R11 cfg");
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, 32'h3060_0000, "R11 version write ignored");
    wr(8'h18, 32'hFF); rd(8'h18, 0, "R11 istat write ignored");
    rd(8'h40, 0, "R11 unmapped");
    // R2 modes
    wr(8'h00, 5); rd(8'h00, 5, "R2 run readback");
    chk("R2 run outputs", {30'd0, modeEnable, modeBlock}, 2'b10);
    wr(8'h00, 3); rd(8'h00, 0, "R2 other value disables");
    wr(8'h00, 7); chk("R2 block outputs", {30'd0, modeEnable, modeBlock}, 2'b11);
    // R3 drain acknowledge
    rd(8'h08, 0, "R3 ack low while busy");
    drainIdle = 1; @(negedge clk); rd(8'h08, 1, "R3 ack after idle");
    wr(8'h00, 5); rd(8'h08, 0, "R3 ack drops when running");
    drainIdle = 0;
    // R4/R5 each fault type
    for (int t = 0; t < 8; t++) begin
      flt(3'(t), 32'h1000_0000 + 32'(t) * 32'h111);
    end
    rd(8'h18, 32'hFF, "R4 all status bits");
    rd(8'h24, 32'h1000_0000, "R5 page fault addr");
    rd(8'h30, 32'h1000_0333, "R5 slave addr");
    rd(8'h2C, 32'h1000_0555, "R5 read side last (type 5)");
    rd(8'h28, 32'h1000_0777, "R5 write side last (type 7)");
    // R6 hold: writes other than run ignored
    wr(8'h00, 0); rd(8'h00, 7, "R6 disable ignored under hold");
    chk("R6 still blocked", 32'(modeBlock), 1);
    // R7 selective clear
    wr(8'h1C, 32'h0F); rd(8'h18, 32'hF0, "R7 partial clear");
    @(negedge clk); regWrEn = 1; regAddr = 8'h1C; regWdata = 32'h10;
    faultValid = 1; faultType = 3'd4; faultAddr = 32'hBEEF_0004;
    @(negedge clk); regWrEn = 0; faultValid = 0;
    rd(8'h18, 32'hF0, "R7 fault beats clear");
    rd(8'h2C, 32'hBEEF_0004, "R5 read side type 4");
    wr(8'h1C, 32'hFF);
    chk("R7 irq cleared", 32'(irq), 0);
    // R6 run write racing a fault
    @(negedge clk); regWrEn = 1; regAddr = 8'h00; regWdata = 5;
    faultValid = 1; faultType = 3'd2; faultAddr = 32'hCAFE_0002;
    @(negedge clk); regWrEn = 0; faultValid = 0;
    chk("R6 fault wins over run", {30'd0, modeEnable, modeBlock}, 2'b11);
    rd(8'h28, 32'hCAFE_0002, "R5 write side type 2");
    wr(8'h00, 5); chk("R6 run releases hold", 32'(modeBlock), 0);
    wr(8'h00, 0); rd(8'h00, 0, "R6 disable accepted after release");
    wr(8'h1C, 32'hFF);
    // R8 flush
    @(negedge clk); regWrEn = 1; regAddr = 8'h0C; regWdata = 1;
    @(negedge clk); regWrEn = 0; #2; chk("R8 flush pulse", 32'(invAllPulse), 1);
    @(negedge clk); #2; chk("R8 pulse one cycle", 32'(invAllPulse), 0);
    wr(8'h0C, 2); #2; chk("R8 bit0 clear no pulse", 32'(invAllPulse), 0);
    // R9 entry
    @(negedge clk); regWrEn = 1; regAddr = 8'h10; regWdata = 32'h1234_5679;
    @(negedge clk); regWrEn = 0; #2;
    chk("R9 entry pulse", 32'(invEntryPulse), 1);
    chk("R9 entry addr", invEntryAddr, 32'h1234_5000);
    wr(8'h10, 32'h0000_8000); #2; chk("R9 bit0 clear no pulse", 32'(invEntryPulse), 0);
    // R10 base
    @(negedge clk); regWrEn = 1; regAddr = 8'h14; regWdata = 32'h8000_4000;
    @(negedge clk); regWrEn = 0; #2; chk("R10 base invalidates", 32'(invAllPulse), 1);
    rd(8'h14, 32'h8000_4000, "R10 base readback");
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule